// File: doc/BRIEF.md
# Quasi-Bidirectional Port Drive Controller

This block generates the digital drive enables for several 8-bit quasi-bidirectional I/O ports. Each pin has an output latch and no direction register. A pin that holds a 1 in its latch is only held high by pull-ups. An outside device can therefore pull the pin low and use it as an input. A pin that holds a 0 is pulled low strongly. The CPU writes whole port latches through a write port. It reads the live pin levels through a two-flop synchronizer.

For every pin the block produces one pull-down enable and three pull-up enables:

- **Weak pull-up.** It follows the latch. A global control input can also keep it on for pins whose latch holds 0.
- **Medium pull-up.** It needs both a latch value of 1 and a synchronized pin level of 1.
- **Strong pull-up.** It is a two-cycle boost that fires when a latch bit rises from 0 to 1. It speeds up the low-to-high edge.

Each pin runs a small state machine for the boost, with three states:

- `ST_IDLE`: no boost.
- `ST_BOOST_A`: first boost cycle.
- `ST_BOOST_B`: second boost cycle.

Its transitions are:

- `ST_IDLE` to `ST_BOOST_A` when a write moves the latch bit from 0 to 1.
- `ST_BOOST_A` to `ST_BOOST_B` unconditionally, unless a write clears the bit.
- `ST_BOOST_B` to `ST_IDLE` unconditionally.
- Any state to `ST_IDLE` when a write clears the bit. This is the cancel transition.

Top module: `qbp_ports`

## Requirements
- R1: After reset every latch bit is 1, no strong boost is active, and `rd_data` reads all ones until synchronized pin values arrive.
- R2: When `wr_en[p]` is high at a rising edge, port p's latch loads `wr_data` at that edge. Ports whose `wr_en` bit is low keep their latch.
- R3: `pd_en` for a pin is 1 exactly when that pin's latch bit is 0.
- R4: `weak_en` for a pin is 1 when its latch bit is 1. It is also 1 when the latch bit is 0 and `weak_off_low` is 0. It is 0 only when the latch bit is 0 and `weak_off_low` is 1.
- R5: `med_en` for a pin is 1 exactly when its latch bit is 1 and its synchronized pin level is 1.
- R6: `rd_data` equals `pin_in` delayed through two flops. A level present before edge k is read after edge k+1.
- R7: A write that changes a latch bit from 0 to 1 raises that pin's `strong_en` in the same cycle the latch shows 1. It holds for exactly two cycles and then clears. Writing 1 over a 1 starts no boost.
- R8: A write that clears a latch bit during a boost drops `strong_en` in the same cycle. A later 0-to-1 write restarts a full two-cycle boost.
- R9: `pd_en` is never high together with `med_en` or `strong_en` on the same pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | NP | Per-port latch write strobe |
| wr_data | input | W | Data written into the selected latches |
| weak_off_low | input | 1 | When 1, turns off the weak pull-up on pins whose latch holds 0 |
| pin_in | input | NP*W | Raw pin levels, port p in bits [p*W +: W] |
| rd_data | output | NP*W | Synchronized pin levels |
| pd_en | output | NP*W | Pull-down enable per pin |
| weak_en | output | NP*W | Weak pull-up enable per pin |
| med_en | output | NP*W | Medium pull-up enable per pin |
| strong_en | output | NP*W | Strong boost pull-up enable per pin |

## Verification
The assertions assume the following about the inputs:

- `wr_data` and `wr_en` change only away from the clock edge.
- `pin_in` may change in any cycle, because the medium checks use only the synchronized copy.
- The boost-length check assumes that a pin's boost can only restart after its latch has been 0 for at least one edge.

The stimulus meets these assumptions by driving all inputs on the falling edge. A restart always needs an intervening write of 0, and the sweep supplies it: all 256 latch values per port, in order. Pin and `weak_off_low` patterns are varied arithmetically within the same sweep.

// File: rtl/qbp_pkg.sv
package qbp_pkg;
    localparam int PORT_W   = 8;
    localparam int PORT_NUM = 3;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_BOOST_A = 2'd1,
        ST_BOOST_B = 2'd2
    } boost_state_t;
endpackage

// File: rtl/qbp_sync.sv
module qbp_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= '1;
            q      <= '1;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/qbp_pin.sv
module qbp_pin
    import qbp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr,
    input  logic wbit,
    input  logic weak_off_low,
    input  logic pin_sync,
    output logic pd_en,
    output logic weak_en,
    output logic med_en,
    output logic strong_en
);
    logic         latch_q;
    boost_state_t state_q;
    boost_state_t state_d;
    logic         rise;
    logic         clear;

    assign rise  = wr && wbit && !latch_q;
    assign clear = wr && !wbit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            latch_q <= 1'b1;
        end else if (wr) begin
            latch_q <= wbit;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (rise) state_d = ST_BOOST_A;
            end
            ST_BOOST_A: begin
                if (clear) state_d = ST_IDLE;
                else       state_d = ST_BOOST_B;
            end
            ST_BOOST_B: begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        pd_en     = !latch_q;
        weak_en   = latch_q || !weak_off_low;
        med_en    = latch_q && pin_sync;
        strong_en = 1'b0;
        unique case (state_q)
            ST_IDLE:    strong_en = 1'b0;
            ST_BOOST_A: strong_en = 1'b1;
            ST_BOOST_B: strong_en = 1'b1;
            default:    strong_en = 1'b0;
        endcase
    end
endmodule

// File: rtl/qbp_port.sv
module qbp_port #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         weak_off_low,
    input  logic [W-1:0] pin_raw,
    output logic [W-1:0] rd,
    output logic [W-1:0] pd_en,
    output logic [W-1:0] weak_en,
    output logic [W-1:0] med_en,
    output logic [W-1:0] strong_en
);
    logic [W-1:0] pin_s;

    qbp_sync #(.W(W)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_raw),
        .q     (pin_s)
    );

    assign rd = pin_s;

    for (genvar b = 0; b < W; b++) begin : g_pin
        qbp_pin u_pin (
            .clk          (clk),
            .rst_n        (rst_n),
            .wr           (wr),
            .wbit         (wdata[b]),
            .weak_off_low (weak_off_low),
            .pin_sync     (pin_s[b]),
            .pd_en        (pd_en[b]),
            .weak_en      (weak_en[b]),
            .med_en       (med_en[b]),
            .strong_en    (strong_en[b])
        );
    end
endmodule

// File: rtl/qbp_ports.sv
module qbp_ports
    import qbp_pkg::*;
#(
    parameter int NP = PORT_NUM,
    parameter int W  = PORT_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NP-1:0]   wr_en,
    input  logic [W-1:0]    wr_data,
    input  logic            weak_off_low,
    input  logic [NP*W-1:0] pin_in,
    output logic [NP*W-1:0] rd_data,
    output logic [NP*W-1:0] pd_en,
    output logic [NP*W-1:0] weak_en,
    output logic [NP*W-1:0] med_en,
    output logic [NP*W-1:0] strong_en
);
    for (genvar p = 0; p < NP; p++) begin : g_port
        qbp_port #(.W(W)) u_port (
            .clk          (clk),
            .rst_n        (rst_n),
            .wr           (wr_en[p]),
            .wdata        (wr_data),
            .weak_off_low (weak_off_low),
            .pin_raw      (pin_in[p*W +: W]),
            .rd           (rd_data[p*W +: W]),
            .pd_en        (pd_en[p*W +: W]),
            .weak_en      (weak_en[p*W +: W]),
            .med_en       (med_en[p*W +: W]),
            .strong_en    (strong_en[p*W +: W])
        );
    end
endmodule

// File: rtl/qbp_chk.sv
module qbp_chk #(
    parameter int NP = 3,
    parameter int W  = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            weak_off_low,
    input logic [NP*W-1:0] rd_data,
    input logic [NP*W-1:0] pd_en,
    input logic [NP*W-1:0] weak_en,
    input logic [NP*W-1:0] med_en,
    input logic [NP*W-1:0] strong_en
);
    // R9
    pd_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_en & (med_en | strong_en)) == '0);

    // R4
    weak_cov_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (~pd_en & ~weak_en) == '0);

    // R4
    weak_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !weak_off_low |-> (&weak_en));

    // R5
    med_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (med_en & ~rd_data) == '0);

    // R7
    boost_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (strong_en & $past(strong_en) & $past(strong_en, 2)) == '0);

    // R7
    boost_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (strong_en & ~$past(strong_en) & ~$past(pd_en)) == '0);
endmodule

bind qbp_ports qbp_chk #(.NP(NP), .W(W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .weak_off_low (weak_off_low),
    .rd_data      (rd_data),
    .pd_en        (pd_en),
    .weak_en      (weak_en),
    .med_en       (med_en),
    .strong_en    (strong_en)
);

// File: tb/sim_qbp_ports.sv
module sim_qbp_ports;
    localparam int NP = 3;
    localparam int W  = 8;
    localparam time CLK_PERIOD = 10ns;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NP-1:0]   wr_en = '0;
    logic [W-1:0]    wr_data = '0;
    logic            weak_off_low = 1'b0;
    logic [NP*W-1:0] pin_in = '1;
    logic [NP*W-1:0] rd_data, pd_en, weak_en, med_en, strong_en;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    logic [W-1:0]    m_lat [NP];
    int              m_cnt [NP][W];
    logic [NP*W-1:0] m_s1, m_s2;

    always #(CLK_PERIOD/2) clk = ~clk;

    qbp_ports #(.NP(NP), .W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .weak_off_low(weak_off_low), .pin_in(pin_in), .rd_data(rd_data),
        .pd_en(pd_en), .weak_en(weak_en), .med_en(med_en), .strong_en(strong_en)
    );

    task automatic cmp(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_all();
        for (int p = 0; p < NP; p++) begin
            logic [W-1:0] es;
            for (int b = 0; b < W; b++) es[b] = (m_cnt[p][b] > 0);
            cmp("R2/R3 pd_en", pd_en[p*W +: W], ~m_lat[p]);
            cmp("R4 weak_en", weak_en[p*W +: W], m_lat[p] | {W{~weak_off_low}});
            cmp("R5 med_en", med_en[p*W +: W], m_lat[p] & m_s2[p*W +: W]);
            cmp("R6 rd_data", rd_data[p*W +: W], m_s2[p*W +: W]);
            cmp("R7/R8 strong_en", strong_en[p*W +: W], es);
        end
    endtask

    // One cycle: drive on falling edge, update model after rising edge, check on next falling edge
    task automatic step(input logic [NP-1:0] we, input logic [W-1:0] d,
                        input logic [NP*W-1:0] pins, input logic woff);
        wr_en = we; wr_data = d; pin_in = pins; weak_off_low = woff;
        @(posedge clk);
        m_s2 = m_s1;
        m_s1 = pins;
        for (int p = 0; p < NP; p++) begin
            for (int b = 0; b < W; b++) begin
                if (we[p] && d[b] && !m_lat[p][b]) m_cnt[p][b] = 2;
                else if (we[p] && !d[b])           m_cnt[p][b] = 0;
                else if (m_cnt[p][b] > 0)          m_cnt[p][b]--;
            end
            if (we[p]) m_lat[p] = d;
        end
        @(negedge clk);
        wr_en = '0;
        check_all();
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int p = 0; p < NP; p++) begin
            m_lat[p] = '1;
            for (int b = 0; b < W; b++) m_cnt[p][b] = 0;
        end
        m_s1 = '1; m_s2 = '1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        check_all();
        for (int p = 0; p < NP; p++) cmp("R1 reset strong", strong_en[p*W +: W], '0);

        // R2..R7, R9: full latch value sweep per port
        for (int p = 0; p < NP; p++) begin
            for (int v = 0; v < 256; v++) begin
                logic [NP*W-1:0] pins;
                logic woff;
                pins = NP*W'((v * 37 + p * 101) ^ ((v * 13) << 8) ^ ((v * 7) << 16));
                woff = v[0] ^ p[0];
                step(NP'(1) << p, W'(v), pins, woff);
                step('0, 8'h00, pins, woff);
                step('0, 8'h00, ~pins, !woff);
            end
        end

        // R8: cancel mid-boost and restart on port 1
        step(3'b010, 8'h00, '1, 1'b1);
        step(3'b010, 8'hFF, '1, 1'b1);
        step(3'b010, 8'h00, '1, 1'b1);
        step(3'b010, 8'hFF, '1, 1'b1);
        step(3'b010, 8'h0F, '1, 1'b1);
        step(3'b010, 8'hFF, '1, 1'b1);
        step('0, 8'h00, '1, 1'b1);
        step('0, 8'h00, '1, 1'b1);
        // R7: writing 1 over 1 starts no boost
        step(3'b111, 8'hFF, '0, 1'b0);
        step(3'b111, 8'hFF, '0, 1'b0);
        step('0, 8'h00, '0, 1'b0);
        step('0, 8'h00, '0, 1'b0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule